// File: doc/BRIEF.md
# LPC Flash Target Cycle Controller

This block is the bus-facing side of a flash device that sits on a four-bit multiplexed low pin count bus. It watches the frame strobe for the start of a transfer and steps through the fixed nibble sequence of a memory cycle: start code, cycle type, eight address nibbles, turnaround, sync, data and a closing turnaround. It also decides, nibble by nibble, whether it drives the shared data lines or leaves them floating. A completed write produces a single strobe toward the device's command logic. A small behavioural array stands in for the flash cells, with a fixed programming delay.

The host may cut a cycle short by pulling the frame strobe low. The target then lets go of the bus in the same cycle. A write whose data nibbles have already arrived has been handed off by then, and an abort cannot recall it. Two reset inputs, from the interface and from the processor, each deselect the target and put the per-block software lock bits back to their defaults. A reset that lands during programming spoils the block being programmed. Two hardware pins can force write protection over the software locks.

Top module: `lpc_target_ctl`

## Requirements
- R1: A cycle starts only from the last clock on which lframe_n is low, and only if the nibble on lad_in in that clock is 4'b0000; a different last nibble starts nothing, even if 4'b0000 came earlier in the same low stretch.
- R2: The first nibble after the start is the cycle type: lad_in[3:1] = 3'b010 is a read, 3'b011 is a write; any other value ends the cycle and the bus is never driven for it.
- R3: Eight address nibbles follow, most significant first. Address bit 31 = 0 selects the 256-byte array (byte index = bits 7:0, block = bits 7:6); bit 31 = 1 selects the lock registers, block = bits 1:0.
- R4: In a read, after two host turnaround clocks the target drives 4'b0000 (sync) for one clock, then the data low nibble, then the high nibble, then floats lad for two turnaround clocks.
- R5: In a write, two data nibbles follow the address, low nibble first. In the clock after the second, cmd_valid is high for exactly one clock with the full address and byte. Two host turnaround clocks follow, then sync 4'b0000 for one clock, then two clocks with lad floating.
- R6: lframe_n low during any later nibble of a cycle ends the cycle, and lad_oe falls in that same clock; no strobe follows for a write aborted before its data completes.
- R7: An abort after both write data nibbles have arrived still releases the bus at once, but the strobe already issued stands and the byte is still programmed.
- R8: With lframe_n high and no cycle under way, lad_oe stays low whatever lad_in carries, including 4'b0000.
- R9: rp_n low or init_n low forces lad_oe low in the same clock and discards the cycle in progress; cycles after release behave normally.
- R10: A write to lock space sets the lock bit of the selected block to data bit 0; a lock-space read returns 7'b0 followed by that bit. Either reset source sets every lock bit back to 1.
- R11: A block is protected when its lock bit is 1, when it is block 3 and tbl_n is low, or when it is one of blocks 0 to 2 and wp_n is low. A write to a protected block still gets sync and a strobe, but leaves the array unchanged.
- R12: An unprotected array write stores the byte 8 clocks after the strobe. A reset from either source during those clocks cancels the store, and every byte of that block then reads 8'hE7 until a later store to that block completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| rp_n | input | 1 | Interface reset, active low |
| init_n | input | 1 | Processor reset, active low |
| lframe_n | input | 1 | Frame strobe from the host, active low |
| lad_in | input | 4 | Nibble sampled from the shared data lines |
| lad_out | output | 4 | Nibble the target puts on the data lines |
| lad_oe | output | 1 | Drive enable for lad_out; low means floating |
| tbl_n | input | 1 | Forces protection of the top block when low |
| wp_n | input | 1 | Forces protection of the other blocks when low |
| cmd_valid | output | 1 | One-clock strobe for a completed write |
| cmd_addr | output | 32 | Address of the strobed write |
| cmd_data | output | 8 | Byte of the strobed write |

## Verification
Every array byte is written and read back, and a nibble-order or address-shift error shows up as wrong data. Aborts are placed in the address phase, in read sync and after write data. A design that waits a clock to float lad would fight the host, and one that drops the late write would lose data. Both reset pins are pulsed in the middle of a read and during programming, catching a target that keeps driving, locks that survive reset, or a cancelled store that leaves stale bytes looking valid. The start rule, bad cycle types, standby traffic and each protection pin against the lock bits are probed one at a time.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_WDATA,
    ST_HTAR,
    ST_SYNC,
    ST_RDATA,
    ST_TTAR
  } lpc_state_e;

  localparam logic [2:0] CYC_READ  = 3'b010;
  localparam logic [2:0] CYC_WRITE = 3'b011;

endpackage

// File: rtl/lpc_cycle_fsm.sv
module lpc_cycle_fsm
  import lpc_pkg::*;
#(
  parameter logic [3:0] START_CODE = 4'h0,
  parameter int         ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              lframe_n,
  input  logic [3:0]        lad_in,
  input  logic [7:0]        rd_byte,
  output logic              oe_q,
  output logic [3:0]        lad_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);

  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int CW       = (ADDR_NIB > 2) ? $clog2(ADDR_NIB) : 1;

  lpc_state_e    st, nst;
  logic [CW-1:0] cnt, ncnt;
  logic          is_wr;
  logic [3:0]    wlo;
  logic [7:0]    rbuf;

  always_comb begin
    nst  = st;
    ncnt = cnt;
    if (!lframe_n) begin
      nst  = (lad_in == START_CODE) ? ST_START : ST_IDLE;
      ncnt = '0;
    end else begin
      case (st)
        ST_IDLE: nst = ST_IDLE;
        ST_START: begin
          ncnt = '0;
          if (lad_in[3:1] == CYC_READ || lad_in[3:1] == CYC_WRITE) nst = ST_ADDR;
          else nst = ST_IDLE;
        end
        ST_ADDR: begin
          if (cnt == CW'(ADDR_NIB - 1)) begin
            nst  = is_wr ? ST_WDATA : ST_HTAR;
            ncnt = '0;
          end else begin
            ncnt = cnt + CW'(1);
          end
        end
        ST_WDATA, ST_HTAR, ST_RDATA, ST_TTAR: begin
          if (cnt == CW'(1)) begin
            ncnt = '0;
            case (st)
              ST_WDATA: nst = ST_HTAR;
              ST_HTAR:  nst = ST_SYNC;
              ST_RDATA: nst = ST_TTAR;
              default:  nst = ST_IDLE;
            endcase
          end else begin
            ncnt = cnt + CW'(1);
          end
        end
        ST_SYNC: begin
          ncnt = '0;
          nst  = is_wr ? ST_TTAR : ST_RDATA;
        end
        default: nst = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      is_wr     <= 1'b0;
      addr_q    <= '0;
      wlo       <= '0;
      rbuf      <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      oe_q      <= 1'b0;
      lad_q     <= '0;
    end else begin
      st        <= nst;
      cnt       <= ncnt;
      cmd_valid <= 1'b0;
      oe_q      <= (nst == ST_SYNC) || (nst == ST_RDATA);
      lad_q     <= (nst == ST_RDATA) ? (ncnt[0] ? rbuf[7:4] : rbuf[3:0]) : 4'h0;
      if (lframe_n) begin
        case (st)
          ST_START: is_wr  <= lad_in[1];
          ST_ADDR:  addr_q <= {addr_q[ADDR_W-5:0], lad_in};
          ST_WDATA: begin
            if (cnt == '0) begin
              wlo <= lad_in;
            end else begin
              cmd_valid <= 1'b1;
              cmd_addr  <= addr_q;
              cmd_data  <= {lad_in, wlo};
            end
          end
          ST_HTAR:  if (cnt[0]) rbuf <= rd_byte;
          default:  ;
        endcase
      end
    end
  end

  // R6: a low frame strobe in mid-cycle sends the sequencer back to idle or start
  p_abort_ends_cycle_r6: assert property (@(posedge clk) disable iff (rst_i)
    (!lframe_n && st != ST_IDLE && st != ST_START) |=> (st == ST_IDLE || st == ST_START));

  // R5: the write strobe never lasts more than one clock
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst_i)
    cmd_valid |=> !cmd_valid);

  // R4: the first data nibble of a read always comes straight after sync
  p_data_after_sync_r4: assert property (@(posedge clk) disable iff (rst_i)
    (st == ST_RDATA && cnt == '0) |-> $past(st) == ST_SYNC);

  // R8: the registered drive enable is only ever set in sync or read data
  p_drive_only_in_slot_r8: assert property (@(posedge clk) disable iff (rst_i)
    oe_q |-> (st == ST_SYNC || st == ST_RDATA));

endmodule

// File: rtl/lpc_lock_regs.sv
module lpc_lock_regs #(
  parameter int   BLK_W     = 2,
  parameter logic LOCK_INIT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_i,
  input  logic                  wr_en,
  input  logic [BLK_W-1:0]      wr_blk,
  input  logic                  wr_val,
  input  logic                  tbl_n,
  input  logic                  wp_n,
  output logic [(1<<BLK_W)-1:0] lock_q,
  output logic [(1<<BLK_W)-1:0] prot
);

  localparam int NUM_BLK = 1 << BLK_W;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst_i)                                   lock_q[b] <= LOCK_INIT;
      else if (wr_en && wr_blk == BLK_W'(b))       lock_q[b] <= wr_val;
    end
    if (b == NUM_BLK - 1) begin : g_top
      assign prot[b] = lock_q[b] | ~tbl_n;
    end else begin : g_rest
      assign prot[b] = lock_q[b] | ~wp_n;
    end
  end

  // R10: the clock after any reset sees every lock bit at its default
  p_lock_default_r10: assert property (@(posedge clk) disable iff (rst_i)
    $past(rst_i) |-> (lock_q == {NUM_BLK{LOCK_INIT}}));

endmodule

// File: rtl/lpc_mem_model.sv
module lpc_mem_model #(
  parameter int         ARR_AW   = 8,
  parameter int         BLK_W    = 2,
  parameter int         PROG_CYC = 8,
  parameter logic [7:0] BAD_BYTE = 8'hE7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              prog_req,
  input  logic [ARR_AW-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  output logic              busy
);

  localparam int DEPTH   = 1 << ARR_AW;
  localparam int NUM_BLK = 1 << BLK_W;
  localparam int CNT_W   = $clog2(PROG_CYC + 1);

  logic [7:0]        mem [DEPTH];
  logic [7:0]        rd_q;
  logic [BLK_W-1:0]  ra_blk_q;
  logic [ARR_AW-1:0] pa;
  logic [7:0]        pd;
  logic [CNT_W-1:0]  cnt;
  logic [NUM_BLK-1:0] inval;
  logic              we;
  logic [BLK_W-1:0]  pa_blk;

  assign pa_blk = pa[ARR_AW-1 -: BLK_W];
  assign we     = busy && (cnt == '0) && !soft_rst;

  always_ff @(posedge clk) begin
    if (we) mem[pa] <= pd;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      pa       <= '0;
      pd       <= '0;
      inval    <= '0;
      ra_blk_q <= '0;
    end else begin
      ra_blk_q <= rd_addr[ARR_AW-1 -: BLK_W];
      if (busy && soft_rst) begin
        busy          <= 1'b0;
        inval[pa_blk] <= 1'b1;
      end else if (we) begin
        busy          <= 1'b0;
        inval[pa_blk] <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
      end else if (prog_req && !soft_rst) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(PROG_CYC - 1);
        pa   <= prog_addr;
        pd   <= prog_data;
      end
    end
  end

  assign rd_data = inval[ra_blk_q] ? BAD_BYTE : rd_q;

  // R12: a reset that cuts a store short leaves its block marked spoiled
  p_cut_store_spoils_r12: assert property (@(posedge clk) disable iff (rst)
    (busy && soft_rst) |=> inval[pa_blk]);

  // R12: a completed store clears its block mark and frees the model
  p_store_clears_r12: assert property (@(posedge clk) disable iff (rst)
    we |=> (!busy && !inval[pa_blk]));

endmodule

// File: rtl/lpc_target_ctl.sv
module lpc_target_ctl #(
  parameter logic [3:0] START_CODE = 4'h0,
  parameter int         ADDR_W     = 32,
  parameter int         ARR_AW     = 8,
  parameter int         BLK_W      = 2,
  parameter int         PROG_CYC   = 8,
  parameter logic [7:0] BAD_BYTE   = 8'hE7,
  parameter logic       LOCK_INIT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rp_n,
  input  logic              init_n,
  input  logic              lframe_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  input  logic              tbl_n,
  input  logic              wp_n,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);

  localparam int NUM_BLK = 1 << BLK_W;

  logic               soft_rst, rst_i;
  logic               fsm_oe;
  logic [3:0]         fsm_lad;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         rd_byte, mem_rd;
  logic [NUM_BLK-1:0] lock_q, prot;
  logic               is_lock_wr, prog_req, prog_busy;
  logic [BLK_W-1:0]   wr_arr_blk;
  logic               unused_addr_bits;

  assign soft_rst = ~rp_n | ~init_n;
  assign rst_i    = rst | soft_rst;

  lpc_cycle_fsm #(
    .START_CODE (START_CODE),
    .ADDR_W     (ADDR_W)
  ) u_fsm (
    .clk       (clk),
    .rst_i     (rst_i),
    .lframe_n  (lframe_n),
    .lad_in    (lad_in),
    .rd_byte   (rd_byte),
    .oe_q      (fsm_oe),
    .lad_q     (fsm_lad),
    .addr_q    (addr_q),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

  assign is_lock_wr = cmd_valid & cmd_addr[ADDR_W-1];
  assign wr_arr_blk = cmd_addr[ARR_AW-1 -: BLK_W];
  assign prog_req   = cmd_valid & ~cmd_addr[ADDR_W-1] & ~prot[wr_arr_blk];

  lpc_lock_regs #(
    .BLK_W     (BLK_W),
    .LOCK_INIT (LOCK_INIT)
  ) u_locks (
    .clk    (clk),
    .rst_i  (rst_i),
    .wr_en  (is_lock_wr),
    .wr_blk (cmd_addr[BLK_W-1:0]),
    .wr_val (cmd_data[0]),
    .tbl_n  (tbl_n),
    .wp_n   (wp_n),
    .lock_q (lock_q),
    .prot   (prot)
  );

  lpc_mem_model #(
    .ARR_AW   (ARR_AW),
    .BLK_W    (BLK_W),
    .PROG_CYC (PROG_CYC),
    .BAD_BYTE (BAD_BYTE)
  ) u_mem (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .rd_addr   (addr_q[ARR_AW-1:0]),
    .rd_data   (mem_rd),
    .prog_req  (prog_req),
    .prog_addr (cmd_addr[ARR_AW-1:0]),
    .prog_data (cmd_data),
    .busy      (prog_busy)
  );

  assign rd_byte = addr_q[ADDR_W-1] ? {7'b0, lock_q[addr_q[BLK_W-1:0]]} : mem_rd;

  assign lad_oe  = fsm_oe & lframe_n & rp_n & init_n;
  assign lad_out = fsm_lad;

  assign unused_addr_bits = ^{addr_q[ADDR_W-2:ARR_AW], cmd_addr[ADDR_W-2:ARR_AW], cmd_data[7:1]};

  // R11: a strobed write into a protected block never starts a store
  p_protected_no_store_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_addr[ADDR_W-1] && prot[wr_arr_blk] && !prog_busy) |=> !prog_busy);

endmodule

// File: tb/lpc_target_ctl_tb.sv
module lpc_target_ctl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rp_n = 1'b1, init_n = 1'b1;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        tbl_n = 1'b1, wp_n = 1'b1;
  logic        cmd_valid;
  logic [31:0] cmd_addr;
  logic [7:0]  cmd_data;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [7:0] exp_mem [256];
  logic [3:0] exp_lock;
  logic [3:0] bad_blk;

  logic        s_oe [19];
  logic        s_now [19];
  logic [3:0]  s_out [19];
  logic        s_cv [19];
  logic [31:0] s_ca [19];
  logic [7:0]  s_cd [19];

  localparam logic [3:0] RD = 4'h4, WR = 4'h6;

  always #10 clk = ~clk;

  lpc_target_ctl u_dut (
    .clk(clk), .rst(rst), .rp_n(rp_n), .init_n(init_n), .lframe_n(lframe_n),
    .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe), .tbl_n(tbl_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_prot(input logic [1:0] b);
    return exp_lock[b] || (b == 2'd3 && !tbl_n) || (b != 2'd3 && !wp_n);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [31:0] a);
    if (a[31]) return {7'b0, exp_lock[a[1:0]]};
    if (bad_blk[a[7:6]]) return 8'hE7;
    return exp_mem[a[7:0]];
  endfunction

  task automatic do_cycle(input logic [3:0] cmdn, input logic [31:0] a, input logic [7:0] d,
                          input logic [3:0] stn, input int ab_k, input int rs_k, input bit rs_init);
    for (int k = 0; k < 19; k++) begin
      logic lf;
      logic [3:0] nb;
      lf = 1'b1;
      nb = 4'hF;
      if (k == 0) begin lf = 1'b0; nb = stn; end
      else if (k == 1) nb = cmdn;
      else if (k <= 9) nb = a[31-4*(k-2) -: 4];
      else if (k == 10 && cmdn[1]) nb = d[3:0];
      else if (k == 11 && cmdn[1]) nb = d[7:4];
      if (ab_k >= 0 && k == ab_k) begin lf = 1'b0; nb = 4'hF; end
      @(negedge clk);
      s_oe[k] = lad_oe; s_out[k] = lad_out; s_cv[k] = cmd_valid;
      s_ca[k] = cmd_addr; s_cd[k] = cmd_data;
      lframe_n = lf;
      lad_in   = nb;
      rp_n     = !(k == rs_k && !rs_init);
      init_n   = !(k == rs_k && rs_init);
      #1 s_now[k] = lad_oe;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!lad_oe, "R8 standby drive", 32'(lad_oe), 0);
      lframe_n = 1'b1;
      lad_in   = 4'(i);
    end
    @(negedge clk);
    lad_in = 4'hF;
  endtask

  task automatic rd(input logic [31:0] a, input string req);
    logic [7:0] v;
    do_cycle(RD, a, 8'h00, 4'h0, -1, -1, 1'b0);
    v = {s_out[14], s_out[13]};
    chk(s_oe[12] && s_out[12] == 4'h0, "R4 sync", {s_oe[12], s_out[12]}, 32'h10);
    chk(!s_oe[11] && !s_oe[15] && !s_oe[16], "R4 turnaround float", {s_oe[11], s_oe[15], s_oe[16]}, 0);
    chk(v == exp_rd(a), req, v, exp_rd(a));
  endtask

  task automatic wr(input logic [31:0] a, input logic [7:0] d);
    do_cycle(WR, a, d, 4'h0, -1, -1, 1'b0);
    chk(s_cv[12] && s_ca[12] == a && s_cd[12] == d, "R5 strobe", s_cv[12] ? {s_ca[12][23:0], s_cd[12]} : 0, {a[23:0], d});
    chk(!s_cv[13] && !s_cv[11], "R5 strobe width", {s_cv[11], s_cv[13]}, 0);
    chk(s_oe[14] && s_out[14] == 4'h0 && !s_oe[13] && !s_oe[15] && !s_oe[16], "R5 sync slot",
        {s_oe[13], s_oe[14], s_oe[15], s_oe[16]}, 32'h4);
    if (a[31]) exp_lock[a[1:0]] = d[0];
    else if (!is_prot(a[7:6])) begin exp_mem[a[7:0]] = d; bad_blk[a[7:6]] = 1'b0; end
  endtask

  task automatic pulse(input bit use_init);
    @(negedge clk);
    if (use_init) init_n = 1'b0; else rp_n = 1'b0;
    #1 chk(!lad_oe, "R9 reset float", 32'(lad_oe), 0);
    @(negedge clk);
    rp_n = 1'b1; init_n = 1'b1;
    exp_lock = 4'hF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    exp_lock = 4'hF;
    bad_blk  = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!lad_oe && !cmd_valid, "R9 reset state", {lad_oe, cmd_valid}, 0);

    // R10 defaults, then unlock all blocks
    for (int b = 0; b < 4; b++) rd(32'h8000_0000 | b, "R10 lock default");
    for (int b = 0; b < 4; b++) wr(32'h8000_0000 | b, 8'h00);
    for (int b = 0; b < 4; b++) rd(32'h8000_0000 | b, "R10 lock cleared");

    // R3 R12 full array sweep
    for (int a = 0; a < 256; a++) begin
      logic [7:0] d;
      d = 8'(a * 37 + 11);
      wr(32'(a), d);
      chk(!s_oe[5] && !s_oe[10], "R3 no drive in address", {s_oe[5], s_oe[10]}, 0);
      rd(32'(a), "R3 R12 sweep readback");
    end

    // R2 unsupported cycle types
    for (int c = 0; c < 16; c++) begin
      if (c[3:1] == 3'b010 || c[3:1] == 3'b011) continue;
      do_cycle(4'(c), 32'h0000_0012, 8'h00, 4'h0, -1, -1, 1'b0);
      for (int k = 0; k < 19; k++)
        chk(!s_oe[k] && !s_cv[k], "R2 bad cycle type ignored", {s_oe[k], s_cv[k]}, 0);
    end
    wr(32'h0000_0012, 8'h44);
    do_cycle(4'hE, 32'h0000_0012, 8'h99, 4'h0, -1, -1, 1'b0);
    rd(32'h0000_0012, "R2 bad write leaves array");

    // R1 start rule with a longer low stretch
    @(negedge clk); lframe_n = 1'b0; lad_in = 4'hF;
    rd(32'h0000_0021, "R1 last low nibble starts");
    @(negedge clk); lframe_n = 1'b0; lad_in = 4'h0;
    do_cycle(RD, 32'h0000_0021, 8'h00, 4'hF, -1, -1, 1'b0);
    for (int k = 0; k < 19; k++) chk(!s_oe[k], "R1 stale start ignored", 32'(s_oe[k]), 0);

    // R8 standby with start-like nibbles while frame is high
    idle(40);

    // R6 abort in read sync
    do_cycle(RD, 32'h0000_0033, 8'h00, 4'h0, 12, -1, 1'b0);
    chk(s_oe[12] && !s_now[12], "R6 abort floats at once", {s_oe[12], s_now[12]}, 32'h2);
    for (int k = 13; k < 19; k++) chk(!s_oe[k], "R6 abort stays off", 32'(s_oe[k]), 0);
    rd(32'h0000_0033, "R6 cycle after abort");

    // R6 abort in address phase of a write
    do_cycle(WR, 32'h0000_0034, 8'h5D, 4'h0, 6, -1, 1'b0);
    for (int k = 0; k < 19; k++) chk(!s_cv[k] && !s_oe[k], "R6 no strobe after early abort", {s_cv[k], s_oe[k]}, 0);
    idle(4);
    rd(32'h0000_0034, "R6 array untouched");

    // R7 abort in write sync after data
    do_cycle(WR, 32'h0000_0035, 8'hA6, 4'h0, 14, -1, 1'b0);
    chk(s_cv[12] && s_cd[12] == 8'hA6, "R7 strobe stands", {s_cv[12], s_cd[12]}, 32'h1A6);
    chk(s_oe[14] && !s_now[14], "R7 bus released", {s_oe[14], s_now[14]}, 32'h2);
    exp_mem[8'h35] = 8'hA6;
    idle(10);
    rd(32'h0000_0035, "R7 late abort still stores");

    // R11 hardware protection over clear locks
    tbl_n = 1'b0;
    wr(32'h0000_00C5, 8'h11);
    wr(32'h0000_0005, 8'h22);
    idle(10);
    rd(32'h0000_00C5, "R11 tbl protects top");
    rd(32'h0000_0005, "R11 tbl spares others");
    tbl_n = 1'b1; wp_n = 1'b0;
    wr(32'h0000_0045, 8'h33);
    wr(32'h0000_00C6, 8'h44);
    idle(10);
    rd(32'h0000_0045, "R11 wp protects lower");
    rd(32'h0000_00C6, "R11 wp spares top");
    wp_n = 1'b1;
    wr(32'h8000_0002, 8'h01);
    wr(32'h0000_0085, 8'h55);
    wr(32'h0000_0046, 8'h66);
    idle(10);
    rd(32'h0000_0085, "R11 lock bit protects");
    rd(32'h0000_0046, "R11 clear lock stores");

    // R9 R10 reset in a read, lock revert
    wr(32'h8000_0002, 8'h00);
    do_cycle(RD, 32'h0000_0046, 8'h00, 4'h0, -1, 13, 1'b0);
    exp_lock = 4'hF;
    chk(s_oe[13] && !s_now[13], "R9 rp float at once", {s_oe[13], s_now[13]}, 32'h2);
    for (int k = 14; k < 19; k++) chk(!s_oe[k], "R9 cycle discarded", 32'(s_oe[k]), 0);
    rd(32'h8000_0002, "R10 rp restores lock");
    rd(32'h0000_0046, "R9 read after reset");
    wr(32'h8000_0001, 8'h00);
    pulse(1'b1);
    rd(32'h8000_0001, "R10 init restores lock");

    // R12 reset during a store spoils the block
    wr(32'h8000_0001, 8'h00);
    do_cycle(WR, 32'h0000_0047, 8'h3C, 4'h0, -1, 17, 1'b1);
    exp_lock = 4'hF;
    bad_blk[1] = 1'b1;
    idle(12);
    rd(32'h0000_0047, "R12 spoiled byte");
    rd(32'h0000_0050, "R12 spoiled block");
    wr(32'h8000_0001, 8'h00);
    wr(32'h0000_0047, 8'h3C);
    idle(10);
    rd(32'h0000_0047, "R12 store recovers");
    rd(32'h0000_0050, "R12 block valid again");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule